// File: doc/BRIEF.md
# Test Vector Burst Sequencer

This block plays back a list of test vectors held in an internal register array. A start request begins a burst at vector 0. Each vector is presented for one test period, and the period length in clock cycles is captured when the burst starts. Each vector holds one 4-bit symbol per pin and a halt flag. The burst runs forward through the list. It stops once a halt-flagged vector has been presented for its whole period.

For every pin, the current symbol is decoded into three outputs for the downstream waveform formatter and response checker: a drive-enable bit, a drive-data bit and a 2-bit expected-compare code. Some symbols only drive, some only compare, and some do both at once. The sequencer marks the first cycle of every period with a pulse. It holds a busy flag for the whole burst and gives a one-cycle done pulse when the burst ends. Vectors are loaded one at a time through a simple write port before the burst.

Top module: `vsq_burst_seq`

## Requirements
- R1: Symbol code 0 drives 0 and code 1 drives 1 (drive enable 1), with compare code 0 (none). Compare codes are 0 none, 1 low, 2 high, 3 tri-state.
- R2: Codes 2, 3, 4 and 5 do not drive (drive enable 0, data 0) and give compare codes 2 (high), 1 (low), 0 (don't care) and 3 (tri-state) respectively. A pin with compare code 3 is never driven.
- R3: The combined codes each drive and compare at the same time: 6 drives 0 and compares low, 7 drives 0 and compares high, 8 drives 1 and compares high, 9 drives 1 and compares low.
- R4: Codes 10 to 15 behave as don't care (no drive, compare code 0).
- R5: The cycle after a start is accepted, busy rises and vector 0 is presented. Each vector is presented for exactly P cycles, and vec_idx shows its index. period_start is high only in the first cycle of each vector.
- R6: A halt-flagged vector is presented for its full P cycles. busy then falls, and done is high for exactly one cycle, namely the first cycle in which busy is low.
- R7: A start request while busy is high is ignored. This includes a request in the final cycle of the halt vector.
- R8: While busy is low, drv_en, drv_data and cmp_code are all zero and period_start is low, whatever the memory holds.
- R9: P is the value of period_len at the cycle the start is accepted, with 0 treated as 1. Changing period_len during a burst has no effect.
- R10: After reset, busy, done, period_start and all drive and compare outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write one vector into the store |
| wr_addr | input | AW | Index of the vector being written |
| wr_syms | input | NPIN*4 | Symbol codes, pin p in bits [4p+3:4p] |
| wr_halt | input | 1 | Halt flag of the vector being written |
| period_len | input | PW | Period length in cycles, sampled at burst start |
| start | input | 1 | Burst start request |
| drv_en | output | NPIN | Per-pin drive enable |
| drv_data | output | NPIN | Per-pin drive level |
| cmp_code | output | NPIN*2 | Per-pin expected compare code, pin p in bits [2p+1:2p] |
| period_start | output | 1 | First cycle of a vector period |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle pulse after the halt vector's period |
| vec_idx | output | AW | Index of the vector being presented |

## Verification
The hardest case to reach from the ports is a start request that lands in the very last cycle of the halt vector. At that edge busy is still high, so the request must be dropped even though the block goes idle at the same edge. The bench computes the last-cycle offset of the burst from its own copy of the vector list and the captured period length. It then places a start pulse exactly there and checks that done appears once and busy stays low afterwards. Random bursts also change period_len in the middle of a run and use period length 0, so the value captured at the start is the one that is exercised.

// File: rtl/vsq_pkg.sv
package vsq_pkg;

  typedef enum logic [3:0] {
    SYM_F0   = 4'd0,
    SYM_F1   = 4'd1,
    SYM_CH   = 4'd2,
    SYM_CL   = 4'd3,
    SYM_X    = 4'd4,
    SYM_Z    = 4'd5,
    SYM_F0CL = 4'd6,
    SYM_F0CH = 4'd7,
    SYM_F1CH = 4'd8,
    SYM_F1CL = 4'd9
  } sym_e;

  localparam logic [1:0] CMP_NONE = 2'd0;
  localparam logic [1:0] CMP_LOW  = 2'd1;
  localparam logic [1:0] CMP_HIGH = 2'd2;
  localparam logic [1:0] CMP_TRI  = 2'd3;

  typedef struct packed {
    logic       en;
    logic       dat;
    logic [1:0] cmp;
  } pin_act_t;

  function automatic pin_act_t sym_to_act(input logic [3:0] code);
    pin_act_t a;
    a = '{en: 1'b0, dat: 1'b0, cmp: CMP_NONE};
    case (code)
      SYM_F0:   a = '{en: 1'b1, dat: 1'b0, cmp: CMP_NONE};
      SYM_F1:   a = '{en: 1'b1, dat: 1'b1, cmp: CMP_NONE};
      SYM_CH:   a = '{en: 1'b0, dat: 1'b0, cmp: CMP_HIGH};
      SYM_CL:   a = '{en: 1'b0, dat: 1'b0, cmp: CMP_LOW};
      SYM_Z:    a = '{en: 1'b0, dat: 1'b0, cmp: CMP_TRI};
      SYM_F0CL: a = '{en: 1'b1, dat: 1'b0, cmp: CMP_LOW};
      SYM_F0CH: a = '{en: 1'b1, dat: 1'b0, cmp: CMP_HIGH};
      SYM_F1CH: a = '{en: 1'b1, dat: 1'b1, cmp: CMP_HIGH};
      SYM_F1CL: a = '{en: 1'b1, dat: 1'b1, cmp: CMP_LOW};
      default:  a = '{en: 1'b0, dat: 1'b0, cmp: CMP_NONE};
    endcase
    return a;
  endfunction

endpackage

// File: rtl/vsq_store.sv
module vsq_store #(
  parameter int NPIN  = 8,
  parameter int DEPTH = 16,
  parameter int SW    = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int VW   = NPIN * SW
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [VW-1:0] wr_syms,
  input  logic          wr_halt,
  input  logic [AW-1:0] rd_addr,
  output logic [VW-1:0] rd_syms,
  output logic          rd_halt
);

  logic [VW-1:0] syms_q [DEPTH];
  logic          halt_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_addr == AW'(e));
    always_ff @(posedge clk) begin
      if (hit) begin
        syms_q[e] <= wr_syms;
        halt_q[e] <= wr_halt;
      end
    end
  end

  assign rd_syms = syms_q[rd_addr];
  assign rd_halt = halt_q[rd_addr];

endmodule

// File: rtl/vsq_timer.sv
module vsq_timer #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [PW-1:0] len,
  input  logic          run,
  output logic [PW-1:0] cnt,
  output logic          last
);

  logic [PW-1:0] plen_q, plen_d;
  logic [PW-1:0] cnt_q, cnt_d;

  always_comb begin
    plen_d = plen_q;
    cnt_d  = cnt_q;
    if (load) begin
      plen_d = (len == '0) ? PW'(1) : len;
      cnt_d  = '0;
    end else if (run) begin
      cnt_d = last ? '0 : cnt_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plen_q <= PW'(1);
      cnt_q  <= '0;
    end else begin
      plen_q <= plen_d;
      cnt_q  <= cnt_d;
    end
  end

  assign last = run && (cnt_q == plen_q - PW'(1));
  assign cnt  = cnt_q;

  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < plen_q));

  p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !last && !load) |=> (cnt_q == $past(cnt_q) + PW'(1)));

endmodule

// File: rtl/vsq_pin_dec.sv
module vsq_pin_dec
  import vsq_pkg::*;
#(
  parameter int NPIN = 8,
  localparam int SW  = 4
) (
  input  logic              active,
  input  logic [NPIN*SW-1:0] syms,
  output logic [NPIN-1:0]   drv_en,
  output logic [NPIN-1:0]   drv_data,
  output logic [NPIN*2-1:0] cmp_code
);

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    pin_act_t act;
    always_comb begin
      act = sym_to_act(syms[p*SW +: SW]);
      if (!active) act = '0;
    end
    assign drv_en[p]         = act.en;
    assign drv_data[p]       = act.dat;
    assign cmp_code[p*2 +: 2] = act.cmp;
  end

endmodule

// File: rtl/vsq_burst_seq.sv
module vsq_burst_seq
  import vsq_pkg::*;
#(
  parameter int NPIN  = 8,
  parameter int DEPTH = 16,
  parameter int PW    = 8,
  localparam int SW   = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [NPIN*SW-1:0] wr_syms,
  input  logic               wr_halt,
  input  logic [PW-1:0]      period_len,
  input  logic               start,
  output logic [NPIN-1:0]    drv_en,
  output logic [NPIN-1:0]    drv_data,
  output logic [NPIN*2-1:0]  cmp_code,
  output logic               period_start,
  output logic               busy,
  output logic               done,
  output logic [AW-1:0]      vec_idx
);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  logic               busy_q, busy_d;
  logic               done_q, done_d;
  logic [AW-1:0]      idx_q, idx_d;
  logic               accept;
  logic [PW-1:0]      cnt;
  logic               last;
  logic [NPIN*SW-1:0] cur_syms;
  logic               cur_halt;

  assign accept = start && !busy_q;

  vsq_store #(.NPIN(NPIN), .DEPTH(DEPTH), .SW(SW)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_syms (wr_syms),
    .wr_halt (wr_halt),
    .rd_addr (idx_q),
    .rd_syms (cur_syms),
    .rd_halt (cur_halt)
  );

  vsq_timer #(.PW(PW)) u_timer (
    .clk   (clk),
    .rst_n (rst_s),
    .load  (accept),
    .len   (period_len),
    .run   (busy_q),
    .cnt   (cnt),
    .last  (last)
  );

  vsq_pin_dec #(.NPIN(NPIN)) u_dec (
    .active   (busy_q),
    .syms     (cur_syms),
    .drv_en   (drv_en),
    .drv_data (drv_data),
    .cmp_code (cmp_code)
  );

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    done_d = 1'b0;
    if (accept) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (busy_q && last) begin
      if (cur_halt) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        idx_d = idx_q + AW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      idx_q  <= idx_d;
    end
  end

  assign busy         = busy_q;
  assign done         = done_q;
  assign vec_idx      = idx_q;
  assign period_start = busy_q && (cnt == '0);

  p_pstart_busy_r5: assert property (@(posedge clk) disable iff (!rst_s)
    period_start |-> busy);

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_s)
    done |=> !done);

  p_done_after_busy_r6: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(done) |-> (!busy && $past(busy)));

  p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_s)
    (busy && start && !last) |=> (busy && $stable(vec_idx)));

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_s)
    !busy |-> (drv_en == '0 && cmp_code == '0 && !period_start));

  for (genvar p = 0; p < NPIN; p++) begin : g_chk
    p_tri_undriven_r2: assert property (@(posedge clk) disable iff (!rst_s)
      (cmp_code[p*2 +: 2] == CMP_TRI) |-> !drv_en[p]);
  end

endmodule

// File: tb/sim_vsq_burst_seq.sv
module sim_vsq_burst_seq;

  localparam int NPIN  = 8;
  localparam int DEPTH = 16;
  localparam int PW    = 8;
  localparam int AW    = 4;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               wr_en = 1'b0;
  logic [AW-1:0]      wr_addr = '0;
  logic [NPIN*4-1:0]  wr_syms = '0;
  logic               wr_halt = 1'b0;
  logic [PW-1:0]      period_len = '0;
  logic               start = 1'b0;
  logic [NPIN-1:0]    drv_en, drv_data;
  logic [NPIN*2-1:0]  cmp_code;
  logic               period_start, busy, done;
  logic [AW-1:0]      vec_idx;

  int errors = 0;
  int checks = 0;

  logic [3:0] mcode [DEPTH][NPIN];
  logic       mhalt [DEPTH];

  always #2 clk = ~clk;

  vsq_burst_seq #(.NPIN(NPIN), .DEPTH(DEPTH), .PW(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_syms(wr_syms), .wr_halt(wr_halt), .period_len(period_len),
    .start(start), .drv_en(drv_en), .drv_data(drv_data),
    .cmp_code(cmp_code), .period_start(period_start), .busy(busy),
    .done(done), .vec_idx(vec_idx)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // expected {en, dat, cmp[1:0]} for one symbol code
  function automatic logic [3:0] ref_act(input logic [3:0] c);
    case (c)
      4'd0: return 4'b1000;
      4'd1: return 4'b1100;
      4'd2: return 4'b0010;
      4'd3: return 4'b0001;
      4'd5: return 4'b0011;
      4'd6: return 4'b1001;
      4'd7: return 4'b1010;
      4'd8: return 4'b1110;
      4'd9: return 4'b1101;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] c);
    if (c <= 4'd1) return "R1";
    if (c <= 4'd5) return "R2";
    if (c <= 4'd9) return "R3";
    return "R4";
  endfunction

  task automatic write_vec(input int i);
    @(negedge clk);
    wr_en = 1'b1;
    wr_addr = AW'(i);
    wr_halt = mhalt[i];
    for (int p = 0; p < NPIN; p++) wr_syms[p*4 +: 4] = mcode[i][p];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load_all();
    for (int i = 0; i < DEPTH; i++) write_vec(i);
  endtask

  // runs one burst; a start pulse is injected at offset inj (-1: none),
  // period_len is altered at offset chg (-1: none)
  task automatic run_burst(input int plen, input int inj, input int chg);
    int eff, nvec, total;
    eff = (plen == 0) ? 1 : plen;
    nvec = DEPTH;
    for (int k = 0; k < DEPTH; k++) if (mhalt[k]) begin nvec = k + 1; break; end
    total = nvec * eff;
    @(negedge clk);
    period_len = PW'(plen);
    start = 1'b1;
    for (int t = 0; t <= total + 1; t++) begin
      @(negedge clk);
      start = 1'b0;
      if (t < total) begin
        int v;
        v = t / eff;
        check("R5 busy", 64'(busy), 64'(1));
        check("R5 period_start", 64'(period_start), 64'((t % eff) == 0));
        check("R5 vec_idx", 64'(vec_idx), 64'(v % DEPTH));
        check("R6 no early done", 64'(done), 64'(0));
        if ((t % eff) == 0) begin
          for (int p = 0; p < NPIN; p++) begin
            logic [3:0] e;
            e = ref_act(mcode[v % DEPTH][p]);
            check(req_of(mcode[v % DEPTH][p]),
                  64'({drv_en[p], drv_data[p], cmp_code[p*2 +: 2]}), 64'(e));
          end
        end
      end else if (t == total) begin
        check("R6 busy falls", 64'(busy), 64'(0));
        check("R6 done pulse", 64'(done), 64'(1));
        check("R8 idle outputs", 64'({drv_en, drv_data, cmp_code, period_start}), 64'(0));
      end else begin
        check("R6 done one cycle", 64'(done), 64'(0));
        check("R7 stays idle", 64'(busy), 64'(0));
      end
      if (t == inj) start = 1'b1;
      if (t == chg) period_len = PW'(plen + 3);
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) begin
      mhalt[i] = 1'b0;
      for (int p = 0; p < NPIN; p++) mcode[i][p] = 4'(i + p);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 reset", 64'({busy, done, period_start, drv_en, drv_data, cmp_code}), 64'(0));

    // directed: every code on some pin, halt on vector 1, P=3
    for (int p = 0; p < NPIN; p++) begin
      mcode[0][p] = 4'(p);
      mcode[1][p] = 4'(p + 8);
    end
    mhalt[1] = 1'b1;
    load_all();
    @(negedge clk);
    check("R8 idle with loaded store", 64'({drv_en, drv_data, cmp_code}), 64'(0));
    run_burst(3, -1, -1);

    // directed: halt on vector 0, period 0 behaves as 1 (R9)
    mhalt[0] = 1'b1;
    write_vec(0);
    run_burst(0, -1, -1);

    // directed: start in the halt vector's final cycle is ignored (R7)
    mhalt[0] = 1'b0;
    write_vec(0);
    run_burst(2, 3, -1);

    // directed: period_len change mid-burst has no effect (R9), start mid-burst (R7)
    run_burst(4, 2, 1);

    // random bursts
    for (int r = 0; r < 14; r++) begin
      int h, pl, inj, chg;
      h = $urandom_range(DEPTH - 1, 0);
      pl = $urandom_range(5, 0);
      for (int i = 0; i < DEPTH; i++) begin
        mhalt[i] = (i == h);
        for (int p = 0; p < NPIN; p++) mcode[i][p] = 4'($urandom_range(15, 0));
      end
      load_all();
      inj = ($urandom_range(1, 0) == 1) ? $urandom_range(h, 0) : -1;
      chg = $urandom_range(h, 0);
      run_burst(pl, inj, chg);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule